// File: doc/BRIEF.md
# Three-Channel Timer Register Interface

This block sits between a processor's 8-bit register bus and three independent down-counting timer channels. It decodes the bus strobes and address, keeps one configuration per channel (access order, counting mode, decimal flag), assembles byte-wise count loads into 16-bit values, and returns the bytes of each channel's count to the processor. The counting logic and output waveform generation live in the channels themselves; this block only hands them configuration and load values and takes back their live counts and output levels.

A channel is set up by writing a control byte to the control address and then its count bytes to the channel's own address. Reads can return either the live count or a snapshot frozen by a latch command, and a read-back command can queue a status byte describing a channel's configuration and output level. The bus is a synchronous register interface sampled on `clk`: every access is taken in the cycle it is presented and there is no back-pressure, so the processor may issue one access per cycle and read data appears on `dout` from the cycle after the read.

Top module: `pit_bus_ctrl`

## Requirements
- R1: After reset `dout` is 0, every channel reports mode 0 and binary counting, no strobe is high, and every channel uses low-then-high byte order.
- R2: A write with `cs_n`=0, `wr_n`=0, `rd_n`=1 and `addr`=3 whose bits 7:6 name channel 0, 1 or 2 and whose bits 5:4 are non-zero stores bits 5:4 as that channel's byte order, bits 3:1 as its mode and bit 0 as its decimal flag; that channel's configuration strobe is high for the one cycle after the write, and other channels are untouched.
- R3: With byte order 01 one data write of byte d loads 0x00d; with byte order 10 it loads d followed by 0x00 (d in the high byte). The load strobe is high for the one cycle after the write, and the value is on `ch_load_val_o` in that cycle.
- R4: With byte order 11 the first data write is held as the low byte and no load occurs; the second write loads {second, first}. A control byte to the channel returns the write pointer to the low byte.
- R5: With no latch or status pending, reads of a channel return its live count: order 01 always the low byte, 10 always the high byte, 11 alternately low then high starting from low; the byte appears on `dout` in the cycle after the read and `dout` holds between reads.
- R6: A control byte with bits 5:4 = 00 freezes the channel's current count; reads then return the frozen bytes in the channel's order (starting from the low byte) until the read sequence ends, after which reads return the live count.
- R7: A latch command to a channel whose frozen count is not yet fully read is ignored.
- R8: A control byte with bits 7:6 = 11 and bit 4 = 0 queues a status byte for each channel whose select bit is set (bit 1 channel 0, bit 2 channel 1, bit 3 channel 2). The status byte is {output level, 0, byte order[1:0], mode[2:0], decimal flag}; the next read of that channel returns it, ahead of any frozen count.
- R9: Cycles with `cs_n`=1, or with `rd_n` and `wr_n` both low, cause no load, configuration or read; a read at `addr`=3 returns 0.
- R10: A written mode whose bit 1 is set is stored with bit 2 cleared (modes 6 and 7 become 2 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 0..2 channel data, 3 control |
| din | input | 8 | Write data, bit 7 most significant |
| dout | output | 8 | Read data, registered |
| ch_count_i | input | 48 | Live counts, channel i in bits 16i+15:16i |
| ch_out_i | input | 3 | Output level of each channel |
| ch_mode_o | output | 9 | Mode of channel i in bits 3i+2:3i |
| ch_bcd_o | output | 3 | Decimal flag per channel |
| ch_cfg_stb_o | output | 3 | One-cycle configuration strobe per channel |
| ch_load_stb_o | output | 3 | One-cycle count-load strobe per channel |
| ch_load_val_o | output | 48 | Load value, channel i in bits 16i+15:16i |

## Verification
A queued status byte and a frozen count can be pending on the same channel at once, and both compete for the next read. The bench freezes a count, then issues a read-back for the same channel while the live count is moved elsewhere, and judges that the first read returns the status byte and the following read the frozen byte rather than the live one. It also issues a second latch while a frozen count is half read and checks that the remaining byte still comes from the first snapshot.

// File: rtl/pit_bus_pkg.sv
package pit_bus_pkg;
  localparam int NCH = 3;
  localparam int DW  = 8;
  localparam int CW  = 2 * DW;
  localparam int AW  = $clog2(NCH + 1);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LOHI  = 2'b11
  } acc_e;

  typedef struct packed {
    acc_e       acc;
    logic [2:0] mode;
    logic       bcd;
  } chan_cfg_t;

  // Modes with bit 1 set alias onto 2 and 3.
  function automatic logic [2:0] norm_mode(input logic [2:0] m);
    return m[1] ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/pit_bus_decode.sv
module pit_bus_decode
  import pit_bus_pkg::*;
(
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [NCH-1:0] cw_prog,
  output logic [NCH-1:0] cw_latch,
  output logic [NCH-1:0] rb_status,
  output logic [NCH-1:0] data_wr,
  output logic [NCH-1:0] data_rd,
  output logic           rd_any,
  output logic           rd_ctrl
);
  logic wr_cyc, rd_cyc, is_ctrl;
  logic [1:0] sc, rwf;

  assign wr_cyc  = !cs_n && !wr_n && rd_n;
  assign rd_cyc  = !cs_n && !rd_n && wr_n;
  assign is_ctrl = (addr == CTRL_ADDR);
  assign sc      = din[7:6];
  assign rwf     = din[5:4];
  assign rd_any  = rd_cyc;
  assign rd_ctrl = rd_cyc && is_ctrl;

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign data_wr[i]   = wr_cyc && (addr == AW'(i));
    assign data_rd[i]   = rd_cyc && (addr == AW'(i));
    assign cw_prog[i]   = wr_cyc && is_ctrl && (sc == 2'(i)) && (rwf != 2'b00);
    assign cw_latch[i]  = wr_cyc && is_ctrl && (sc == 2'(i)) && (rwf == 2'b00);
    assign rb_status[i] = wr_cyc && is_ctrl && (sc == 2'b11) && !din[4] && din[i+1];
  end
endmodule

// File: rtl/pit_wr_chan.sv
module pit_wr_chan
  import pit_bus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_prog,
  input  logic          data_wr,
  input  logic [DW-1:0] din,
  output chan_cfg_t     cfg,
  output logic          cfg_stb,
  output logic          load_stb,
  output logic [CW-1:0] load_val
);
  logic          hi_next;
  logic [DW-1:0] lo_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= '{acc: ACC_LOHI, mode: 3'd0, bcd: 1'b0};
      hi_next  <= 1'b0;
      lo_hold  <= '0;
      cfg_stb  <= 1'b0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      cfg_stb  <= cw_prog;
      load_stb <= 1'b0;
      if (cw_prog) begin
        cfg     <= '{acc: acc_e'(din[5:4]), mode: norm_mode(din[3:1]), bcd: din[0]};
        hi_next <= 1'b0;
      end else if (data_wr) begin
        case (cfg.acc)
          ACC_LO: begin
            load_val <= {{DW{1'b0}}, din};
            load_stb <= 1'b1;
          end
          ACC_HI: begin
            load_val <= {din, {DW{1'b0}}};
            load_stb <= 1'b1;
          end
          ACC_LOHI: begin
            if (!hi_next) begin
              lo_hold <= din;
              hi_next <= 1'b1;
            end else begin
              load_val <= {din, lo_hold};
              load_stb <= 1'b1;
              hi_next  <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pit_rd_chan.sv
module pit_rd_chan
  import pit_bus_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cw_prog,
  input  logic          cw_latch,
  input  logic          rb_status,
  input  logic          data_rd,
  input  chan_cfg_t     cfg,
  input  logic [CW-1:0] live_cnt,
  input  logic          out_i,
  output logic [DW-1:0] rd_byte
);
  logic          latched, rptr_hi, stat_pend;
  logic [CW-1:0] snap, src;
  logic [DW-1:0] stat_byte;

  assign src = latched ? snap : live_cnt;

  always_comb begin
    if (stat_pend) begin
      rd_byte = stat_byte;
    end else begin
      case (cfg.acc)
        ACC_HI:   rd_byte = src[CW-1:DW];
        ACC_LOHI: rd_byte = rptr_hi ? src[CW-1:DW] : src[DW-1:0];
        default:  rd_byte = src[DW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latched   <= 1'b0;
      rptr_hi   <= 1'b0;
      stat_pend <= 1'b0;
      snap      <= '0;
      stat_byte <= '0;
    end else if (cw_prog) begin
      latched   <= 1'b0;
      rptr_hi   <= 1'b0;
      stat_pend <= 1'b0;
    end else begin
      if (cw_latch && !latched) begin
        snap    <= live_cnt;
        latched <= 1'b1;
        rptr_hi <= 1'b0;
      end
      if (rb_status && !stat_pend) begin
        stat_byte <= {out_i, 1'b0, cfg.acc, cfg.mode, cfg.bcd};
        stat_pend <= 1'b1;
      end
      if (data_rd) begin
        if (stat_pend) begin
          stat_pend <= 1'b0;
        end else begin
          case (cfg.acc)
            ACC_LOHI: begin
              if (rptr_hi) begin
                rptr_hi <= 1'b0;
                latched <= 1'b0;
              end else begin
                rptr_hi <= 1'b1;
              end
            end
            default: latched <= 1'b0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pit_bus_ctrl.sv
module pit_bus_ctrl
  import pit_bus_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        din,
  output logic [DW-1:0]        dout,
  input  logic [NCH*CW-1:0]    ch_count_i,
  input  logic [NCH-1:0]       ch_out_i,
  output logic [NCH*3-1:0]     ch_mode_o,
  output logic [NCH-1:0]       ch_bcd_o,
  output logic [NCH-1:0]       ch_cfg_stb_o,
  output logic [NCH-1:0]       ch_load_stb_o,
  output logic [NCH*CW-1:0]    ch_load_val_o
);
  logic [NCH-1:0] cw_prog, cw_latch, rb_status, data_wr, data_rd;
  logic           rd_any, rd_ctrl;
  chan_cfg_t      cfg [NCH];
  logic [DW-1:0]  rd_byte [NCH];
  logic [DW-1:0]  rd_sel;

  pit_bus_decode u_dec (
    .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .din(din),
    .cw_prog(cw_prog), .cw_latch(cw_latch), .rb_status(rb_status),
    .data_wr(data_wr), .data_rd(data_rd), .rd_any(rd_any), .rd_ctrl(rd_ctrl)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pit_wr_chan u_wr (
      .clk(clk), .rst_n(rst_n), .cw_prog(cw_prog[i]), .data_wr(data_wr[i]),
      .din(din), .cfg(cfg[i]), .cfg_stb(ch_cfg_stb_o[i]),
      .load_stb(ch_load_stb_o[i]), .load_val(ch_load_val_o[i*CW +: CW])
    );
    pit_rd_chan u_rd (
      .clk(clk), .rst_n(rst_n), .cw_prog(cw_prog[i]), .cw_latch(cw_latch[i]),
      .rb_status(rb_status[i]), .data_rd(data_rd[i]), .cfg(cfg[i]),
      .live_cnt(ch_count_i[i*CW +: CW]), .out_i(ch_out_i[i]), .rd_byte(rd_byte[i])
    );
    assign ch_mode_o[i*3 +: 3] = cfg[i].mode;
    assign ch_bcd_o[i]         = cfg[i].bcd;
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(i)) rd_sel = rd_byte[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dout <= '0;
    else if (rd_any) dout <= rd_ctrl ? '0 : rd_sel;
  end
endmodule

// File: rtl/pit_bus_ctrl_chk.sv
module pit_bus_ctrl_chk
  import pit_bus_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cs_n,
  input logic                 rd_n,
  input logic                 wr_n,
  input logic [AW-1:0]        addr,
  input logic [DW-1:0]        din,
  input logic [DW-1:0]        dout,
  input logic [NCH*CW-1:0]    ch_count_i,
  input logic [NCH-1:0]       ch_out_i,
  input logic [NCH*3-1:0]     ch_mode_o,
  input logic [NCH-1:0]       ch_bcd_o,
  input logic [NCH-1:0]       ch_cfg_stb_o,
  input logic [NCH-1:0]       ch_load_stb_o,
  input logic [NCH*CW-1:0]    ch_load_val_o
);
  a_r3_load_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_load_stb_o) |-> $past(!cs_n && !wr_n && rd_n && addr != CTRL_ADDR));

  a_r2_cfg_needs_cw: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_cfg_stb_o) |-> $past(!cs_n && !wr_n && rd_n && addr == CTRL_ADDR
                              && din[5:4] != 2'b00 && din[7:6] != 2'b11));

  a_r9_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cs_n) |-> (ch_load_stb_o == '0 && ch_cfg_stb_o == '0));

  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|ch_cfg_stb_o) |-> ($stable(ch_mode_o) && $stable(ch_bcd_o)));

  a_r5_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(!cs_n && !rd_n && wr_n) |-> $stable(dout));

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_load_stb_o) && $onehot0(ch_cfg_stb_o));
endmodule

bind pit_bus_ctrl pit_bus_ctrl_chk u_chk (.*);

// File: tb/sim_pit_bus_ctrl.sv
module sim_pit_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  din = 8'd0;
  logic [7:0]  dout;
  logic [47:0] ch_count_i = '0;
  logic [2:0]  ch_out_i = '0;
  logic [8:0]  ch_mode_o;
  logic [2:0]  ch_bcd_o, ch_cfg_stb_o, ch_load_stb_o;
  logic [47:0] ch_load_val_o;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pit_bus_ctrl u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic c, input logic r, input logic w,
                     input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = c; rd_n = r; wr_n = w; addr = a; din = d;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus(1'b0, 1'b1, 1'b0, a, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] q);
    bus(1'b0, 1'b0, 1'b1, a, 8'h00);
    q = dout;
  endtask

  task automatic t_reset;
    logic [7:0] q;
    chk("R1 dout", {8'h0, dout}, 16'h0);
    chk("R1 mode", {7'h0, ch_mode_o}, 16'h0);
    chk("R1 bcd", {13'h0, ch_bcd_o}, 16'h0);
    chk("R1 strobes", {10'h0, ch_cfg_stb_o, ch_load_stb_o}, 16'h0);
    ch_count_i[15:0] = 16'h1234;
    rd(2'd0, q); chk("R1 default order lo", {8'h0, q}, 16'h0034);
    rd(2'd0, q); chk("R1 default order hi", {8'h0, q}, 16'h0012);
  endtask

  task automatic t_cfg;
    wr(2'd3, 8'h59);  // ch1: order 01, mode 4, decimal
    chk("R2 cfg strobe", {13'h0, ch_cfg_stb_o}, 16'h0002);
    chk("R2 mode ch1", {13'h0, ch_mode_o[5:3]}, 16'h0004);
    chk("R2 bcd", {13'h0, ch_bcd_o}, 16'h0002);
    chk("R2 ch0 untouched", {13'h0, ch_mode_o[2:0]}, 16'h0);
    @(negedge clk); #1;
    chk("R2 strobe one cycle", {13'h0, ch_cfg_stb_o}, 16'h0);
    wr(2'd3, 8'hBC);  // ch2: order 11, mode 6
    chk("R10 mode alias", {13'h0, ch_mode_o[8:6]}, 16'h0002);
  endtask

  task automatic t_load_single;
    wr(2'd1, 8'hA5);
    chk("R3 lo-only strobe", {13'h0, ch_load_stb_o}, 16'h0002);
    chk("R3 lo-only value", ch_load_val_o[31:16], 16'h00A5);
    wr(2'd3, 8'h20);  // ch0: order 10, mode 0
    wr(2'd0, 8'h7E);
    chk("R3 hi-only value", ch_load_val_o[15:0], 16'h7E00);
    chk("R3 hi-only strobe", {13'h0, ch_load_stb_o}, 16'h0001);
    @(negedge clk); #1;
    chk("R3 strobe one cycle", {13'h0, ch_load_stb_o}, 16'h0);
  endtask

  task automatic t_load_pair;
    wr(2'd2, 8'h34);
    chk("R4 no load after first byte", {13'h0, ch_load_stb_o}, 16'h0);
    wr(2'd2, 8'h12);
    chk("R4 load after second", {13'h0, ch_load_stb_o}, 16'h0004);
    chk("R4 pair value", ch_load_val_o[47:32], 16'h1234);
    wr(2'd2, 8'h55);
    wr(2'd3, 8'hBC);
    wr(2'd2, 8'h66);
    chk("R4 pointer reset by cw", {13'h0, ch_load_stb_o}, 16'h0);
    wr(2'd2, 8'h77);
    chk("R4 value after reset", ch_load_val_o[47:32], 16'h7766);
  endtask

  task automatic t_live;
    logic [7:0] q;
    ch_count_i[47:32] = 16'hBEEF;
    rd(2'd2, q); chk("R5 live lo", {8'h0, q}, 16'h00EF);
    rd(2'd2, q); chk("R5 live hi", {8'h0, q}, 16'h00BE);
    ch_count_i[47:32] = 16'h1357;
    rd(2'd2, q); chk("R5 live lo again", {8'h0, q}, 16'h0057);
    rd(2'd2, q); chk("R5 live hi again", {8'h0, q}, 16'h0013);
    ch_count_i[31:16] = 16'h4321;
    rd(2'd1, q); chk("R5 lo-only", {8'h0, q}, 16'h0021);
    rd(2'd1, q); chk("R5 lo-only repeat", {8'h0, q}, 16'h0021);
    @(negedge clk); #1;
    chk("R5 dout holds", {8'h0, dout}, 16'h0021);
  endtask

  task automatic t_latch;
    logic [7:0] q;
    ch_count_i[47:32] = 16'hC3D4;
    wr(2'd3, 8'h80);  // latch ch2
    ch_count_i[47:32] = 16'h1111;
    rd(2'd2, q); chk("R6 frozen lo", {8'h0, q}, 16'h00D4);
    ch_count_i[47:32] = 16'h9988;
    wr(2'd3, 8'h80);  // ignored: latch still pending
    rd(2'd2, q); chk("R7 second latch ignored", {8'h0, q}, 16'h00C3);
    rd(2'd2, q); chk("R6 live after frozen read", {8'h0, q}, 16'h0088);
    rd(2'd2, q); chk("R6 live hi", {8'h0, q}, 16'h0099);
  endtask

  task automatic t_status;
    logic [7:0] q;
    ch_out_i = 3'b001;
    ch_count_i[15:0] = 16'h5A6B;
    wr(2'd3, 8'h00);  // latch ch0 (order 10)
    ch_count_i[15:0] = 16'h0F0F;
    wr(2'd3, 8'hE2);  // status only, ch0
    rd(2'd0, q); chk("R8 status first", {8'h0, q}, 16'h00A0);
    rd(2'd0, q); chk("R8 frozen after status", {8'h0, q}, 16'h005A);
    rd(2'd0, q); chk("R8 live afterwards", {8'h0, q}, 16'h000F);
  endtask

  task automatic t_ignored;
    logic [7:0] q;
    bus(1'b1, 1'b1, 1'b0, 2'd1, 8'hEE);
    chk("R9 deselected write", {13'h0, ch_load_stb_o}, 16'h0);
    bus(1'b0, 1'b0, 1'b0, 2'd3, 8'h59);
    chk("R9 both strobes no cfg", {13'h0, ch_cfg_stb_o}, 16'h0);
    chk("R9 both strobes no read", {8'h0, dout}, 16'h000F);
    rd(2'd3, q); chk("R9 control read zero", {8'h0, q}, 16'h0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset();
    t_cfg();
    t_load_single();
    t_load_pair();
    t_live();
    t_latch();
    t_status();
    t_ignored();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule